// File: doc/BRIEF.md
# Supply Reset Supervisor

This block is a digital model of the logic that holds a chip in reset while its supply is too low. A sampled supply voltage arrives every clock as an unsigned millivolt code. Two threshold comparators watch it, and each has its own rising and falling trip points. The first is a power-on/power-down comparator that never turns off. It trips at 1520 mV on the way up and at 1480 mV on the way down. The second is a brown-out comparator. Its trip pair comes from a five-entry parameter table, chosen by a 3-bit level code, and its two points sit 100 mV apart.

The brown-out enable and level code are static configuration. In a real chip they are loaded from non-volatile option storage. When brown-out is enabled, its comparator alone decides whether the supply is good, which hides the lower power-on thresholds. When it is disabled, the power-on comparator decides, so a supply between the power-down point and the 1.65 V operating minimum (the grey zone) keeps the chip running. The supply-good decision asserts the active-low reset output on the clock edge that detects the drop. Release waits for a temporization counter of `TEMPO_CYC` cycles, and that count restarts whenever the supply-good decision drops again.

Top module: `supply_rst_sup`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released with the supply at 0 mV, `sys_rst_n_o` is 0.
- R2: With brown-out disabled, `sys_rst_n_o` stays 0 while every sampled supply value since the last trip is below 1520 mV.
- R3: `sys_rst_n_o` rises on the (`TEMPO_CYC`+1)-th rising edge counted from the first edge that samples the supply at or above the selected rising trip point, provided the supply-good decision holds over that whole span (`TEMPO_CYC` = 16 by default).
- R4: With brown-out disabled, the first edge that samples the supply below 1480 mV drives `sys_rst_n_o` to 0 after that same edge.
- R5: The power-on comparator has hysteresis. A supply from 1480 to 1519 mV leaves its state unchanged in either direction.
- R6: With brown-out disabled and reset released, supply values from 1480 mV up to 1650 mV keep `sys_rst_n_o` at 1 (grey zone).
- R7: Enabling brown-out masks the power-on comparator. At 1600 mV with level 0 selected, `sys_rst_n_o` goes to 0 after the next edge, even though the power-on comparator is satisfied.
- R8: Brown-out level codes select the following trip pairs, given as rising/falling mV: 0 → 1850/1750, 1 → 2100/2000, 2 → 2400/2300, 3 → 2650/2550, 4 → 2950/2850. A supply below the falling point asserts reset after the sampling edge. A supply at or above the rising point starts the release delay. A supply between the two points holds the current state.
- R9: Level codes 5, 6 and 7 behave exactly like code 4.
- R10: If the supply-good decision drops at any point during the release delay, the counter restarts, and a full `TEMPO_CYC` delay is needed after the decision returns.
- R11: During the release delay, a supply that dips into the hysteresis band without crossing the falling point neither restarts nor stretches the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low initialization of the block's registers |
| vdd_mv_i | input | 13 | Sampled supply voltage in millivolts, unsigned |
| bor_en_i | input | 1 | Brown-out comparator enable (static configuration) |
| bor_lvl_i | input | 3 | Brown-out level code; 5 to 7 saturate to 4 |
| sys_rst_n_o | output | 1 | Active-low system reset |

## Verification
There are two places where the internal state can go wrong, and they show up differently at the output. A comparator stuck on the wrong side of its hysteresis band shows up as the reset output being in the wrong state while the supply sits inside that band, and it becomes visible on the first edge after the supply enters the band. A temporization counter that does not restart, or restarts at the wrong value, shows up as a release that comes one or more cycles early or late. Each release is therefore checked edge by edge against a count taken from the crossing. A level-table or saturation error moves a trip point, so supply values one millivolt on either side of each trip point expose it within one cycle.

// File: rtl/supply_sup_pkg.sv
package supply_sup_pkg;
  localparam int MV_W    = 13;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 5;

  typedef logic [MV_W-1:0] mv_t;

  // Clamp a level code into the populated part of the threshold table.
  function automatic logic [LVL_W-1:0] sat_level(input logic [LVL_W-1:0] code,
                                                 input int unsigned top_idx);
    logic [LVL_W-1:0] top_code;
    top_code = top_idx[LVL_W-1:0];
    return (code > top_code) ? top_code : code;
  endfunction

  // Comparator next state with hysteresis: set at/above rise, clear below fall.
  function automatic logic hyst_next(input logic cur, input mv_t lvl,
                                     input mv_t rise_th, input mv_t fall_th);
    if (!cur && (lvl >= rise_th)) return 1'b1;
    if (cur && (lvl < fall_th))   return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp
  import supply_sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  mv_t  level_i,
  input  mv_t  rise_th_i,
  input  mv_t  fall_th_i,
  output logic above_o
);
  logic above_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= hyst_next(above_q, level_i, rise_th_i, fall_th_i);
  end

  assign above_o = above_q;

  // Falling trip point always wins on the next edge.
  assert_trip_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i < fall_th_i) |=> !above_o);

  // Rising trip point always sets the state on the next edge.
  assert_trip_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_i >= rise_th_i) && (rise_th_i > fall_th_i)) |=> above_o);
endmodule

// File: rtl/bor_thr_sel.sv
module bor_thr_sel
  import supply_sup_pkg::*;
#(
  parameter mv_t [NUM_LVL-1:0] RISE_TBL = '{13'd2950, 13'd2650, 13'd2400, 13'd2100, 13'd1850},
  parameter mv_t [NUM_LVL-1:0] FALL_TBL = '{13'd2850, 13'd2550, 13'd2300, 13'd2000, 13'd1750}
) (
  input  logic [LVL_W-1:0] code_i,
  output mv_t              rise_th_o,
  output mv_t              fall_th_o
);
  logic [LVL_W-1:0] lvl;

  assign lvl = sat_level(code_i, NUM_LVL - 1);

  always_comb begin
    rise_th_o = RISE_TBL[NUM_LVL-1];
    fall_th_o = FALL_TBL[NUM_LVL-1];
    for (int i = 0; i < NUM_LVL; i++) begin
      if (lvl == i[LVL_W-1:0]) begin
        rise_th_o = RISE_TBL[i];
        fall_th_o = FALL_TBL[i];
      end
    end
  end
endmodule

// File: rtl/rst_tempo.sv
module rst_tempo #(
  parameter int TEMPO_CYC = 16,
  localparam int CNT_W = $clog2(TEMPO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  output logic release_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(TEMPO_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!ok_i)          cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign release_o = ok_i && (cnt_q == CNT_TOP);

  // Any loss of the supply-good decision restarts the delay.
  assert_tempo_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_i |=> (cnt_q == '0));

  // Release only emerges after a cycle in which the supply was already good.
  assert_release_after_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_o) |-> $past(ok_i));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
endmodule

// File: rtl/supply_rst_sup.sv
module supply_rst_sup
  import supply_sup_pkg::*;
#(
  parameter mv_t POR_RISE_MV = 13'd1520,
  parameter mv_t POR_FALL_MV = 13'd1480,
  parameter mv_t [NUM_LVL-1:0] BOR_RISE_TBL = '{13'd2950, 13'd2650, 13'd2400, 13'd2100, 13'd1850},
  parameter mv_t [NUM_LVL-1:0] BOR_FALL_TBL = '{13'd2850, 13'd2550, 13'd2300, 13'd2000, 13'd1750},
  parameter int  TEMPO_CYC   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MV_W-1:0]  vdd_mv_i,
  input  logic             bor_en_i,
  input  logic [LVL_W-1:0] bor_lvl_i,
  output logic             sys_rst_n_o
);
  mv_t  bor_rise, bor_fall;
  logic por_good, bor_good, supply_good, tempo_done;

  bor_thr_sel #(
    .RISE_TBL (BOR_RISE_TBL),
    .FALL_TBL (BOR_FALL_TBL)
  ) u_sel (
    .code_i    (bor_lvl_i),
    .rise_th_o (bor_rise),
    .fall_th_o (bor_fall)
  );

  hyst_cmp u_por (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (vdd_mv_i),
    .rise_th_i (POR_RISE_MV),
    .fall_th_i (POR_FALL_MV),
    .above_o   (por_good)
  );

  hyst_cmp u_bor (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (vdd_mv_i),
    .rise_th_i (bor_rise),
    .fall_th_i (bor_fall),
    .above_o   (bor_good)
  );

  // Brown-out, when enabled, masks the power-on/power-down comparator.
  assign supply_good = bor_en_i ? bor_good : por_good;

  rst_tempo #(.TEMPO_CYC(TEMPO_CYC)) u_tempo (
    .clk       (clk),
    .rst_n     (rst_n),
    .ok_i      (supply_good),
    .release_o (tempo_done)
  );

  assign sys_rst_n_o = tempo_done;

  assert_por_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bor_en_i && (vdd_mv_i < POR_FALL_MV)) ##1 !bor_en_i |-> !sys_rst_n_o);

  assert_bor_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_en_i && (vdd_mv_i < bor_fall)) ##1 bor_en_i |-> !sys_rst_n_o);

  assert_bor_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_en_i && !bor_good) |-> !sys_rst_n_o);
endmodule

// File: tb/supply_rst_sup_tb_top.sv
`timescale 1ns/1ps
module supply_rst_sup_tb_top;
  localparam int TEMPO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] vdd = '0;
  logic        bor_en = 1'b0;
  logic [2:0]  bor_lvl = '0;
  logic        sys_rst_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  // Bench reference state.
  bit m_por, m_bor;
  int m_cnt;

  always #2.5 clk = ~clk;

  supply_rst_sup #(.TEMPO_CYC(TEMPO)) dut_i (
    .clk(clk), .rst_n(rst_n), .vdd_mv_i(vdd), .bor_en_i(bor_en),
    .bor_lvl_i(bor_lvl), .sys_rst_n_o(sys_rst_n)
  );

  function automatic int lvl_of(input logic [2:0] c);
    return (c > 3'd4) ? 4 : int'(c);
  endfunction
  function automatic int bor_rise_mv(input logic [2:0] c);
    int r[5] = '{1850, 2100, 2400, 2650, 2950};
    return r[lvl_of(c)];
  endfunction
  function automatic int bor_fall_mv(input logic [2:0] c);
    return bor_rise_mv(c) - 100;
  endfunction

  // Driver: apply one sample at negedge and queue the value expected after the next edge.
  task automatic step(input int mv, input bit en, input logic [2:0] lvl, input string tag);
    bit ok_pre, exp;
    @(negedge clk);
    vdd = 13'(mv); bor_en = en; bor_lvl = lvl;
    ok_pre = en ? m_bor : m_por;
    if (!m_por && mv >= 1520) m_por = 1; else if (m_por && mv < 1480) m_por = 0;
    if (!m_bor && mv >= bor_rise_mv(lvl)) m_bor = 1;
    else if (m_bor && mv < bor_fall_mv(lvl)) m_bor = 0;
    if (!ok_pre) m_cnt = 0; else if (m_cnt < TEMPO) m_cnt++;
    exp = (en ? m_bor : m_por) && (m_cnt == TEMPO);
    sb_q.push_back('{exp, tag});
  endtask

  task automatic hold(input int mv, input bit en, input logic [2:0] lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) step(mv, en, lvl, tag);
  endtask

  // Explicit release-latency check for R3: count edges until release.
  task automatic release_latency(input int mv, input bit en, input logic [2:0] lvl);
    int edges = 0;
    for (int i = 0; i < TEMPO + 4; i++) begin
      step(mv, en, lvl, "R3");
      @(posedge clk); #1;
      edges++;
      if (sys_rst_n) break;
    end
    checks++;
    if (edges != TEMPO + 1) begin
      errors++;
      $display("FAIL R3 release after %0d edges, expected %0d", edges, TEMPO + 1);
    end
  endtask

  // Monitor: compare after each edge.
  always begin
    @(posedge clk); #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (sys_rst_n !== it.exp) begin
        errors++;
        $display("FAIL %s at t=%0t vdd=%0d en=%0b lvl=%0d: sys_rst_n=%b expected %b",
                 it.tag, $time, vdd, bor_en, bor_lvl, sys_rst_n, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_por = 0; m_bor = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    #1; checks++;
    if (sys_rst_n !== 1'b0) begin
      errors++; $display("FAIL R1 in reset: sys_rst_n=%b expected 0", sys_rst_n);
    end
    rst_n = 1'b1;
    hold(0, 0, 0, 3, "R1");
    // Power-on path, brown-out disabled.
    hold(1000, 0, 0, 4, "R2");
    hold(1519, 0, 0, 6, "R2");
    release_latency(1520, 0, 0);
    hold(1600, 0, 0, 3, "R6");
    hold(1500, 0, 0, 4, "R6");
    hold(1650, 0, 0, 2, "R6");
    hold(1481, 0, 0, 2, "R5");
    hold(1480, 0, 0, 2, "R5");
    hold(1479, 0, 0, 2, "R4");
    hold(1519, 0, 0, 5, "R5");
    // Restart on a dip below the falling point.
    hold(1520, 0, 0, 8, "R10");
    hold(1400, 0, 0, 1, "R10");
    hold(1520, 0, 0, TEMPO + 3, "R10");
    // Dip into the band during the delay does not restart it.
    hold(1000, 0, 0, 2, "R4");
    hold(1520, 0, 0, 6, "R11");
    hold(1490, 0, 0, 3, "R11");
    hold(1520, 0, 0, TEMPO, "R11");
    // Brown-out masks power-on.
    hold(1600, 1, 0, 4, "R7");
    hold(1849, 1, 0, 3, "R8");
    release_latency(1850, 1, 0);
    hold(1751, 1, 0, 2, "R8");
    hold(1750, 1, 0, 2, "R8");
    hold(1749, 1, 0, 2, "R8");
    // Level 2.
    hold(2399, 1, 2, 3, "R8");
    hold(2400, 1, 2, TEMPO + 2, "R8");
    hold(2300, 1, 2, 2, "R8");
    hold(2299, 1, 2, 2, "R8");
    hold(2100, 1, 1, TEMPO + 2, "R8");
    hold(1999, 1, 1, 2, "R8");
    // Saturating codes.
    hold(2949, 1, 6, 3, "R9");
    release_latency(2950, 1, 7);
    hold(2850, 1, 5, 2, "R9");
    hold(2849, 1, 5, 2, "R9");
    hold(2700, 1, 7, 3, "R9");
    hold(2950, 1, 4, TEMPO + 2, "R8");
    hold(2849, 1, 4, 2, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule